// File: doc/BRIEF.md
# Per-Frame Serial Parameter Streamer

This block delivers one fixed-length set of threshold parameters per image frame into a downstream bank of serial threshold registers. The parameter bits sit in an external single-bit-wide read memory. For every frame boundary, the streamer steps a read address through 32 consecutive locations. It forwards each returned bit on a serial data line, together with a shift enable. Then it idles until the next boundary.

The streamer runs from the host clock. Internally it works at half that rate, with one step every second host cycle. The frame boundary arrives as a level from the pixel-clock domain. Its rising edge is re-timed into the host domain. The re-timed edge gives a one-cycle parallel-load request to the downstream registers, and it also starts the next burst.

The read address does not restart with each frame. It keeps counting across all the frames of a line, and a separate line-end input clears it. The shift enable trails each address step by two half-rate cycles, which covers the memory read latency.

Top module: `frame_param_streamer`

## Requirements
- R1: While reset is asserted (rstN low, active low), ramAddr, shiftEn, shiftData and loadReq are all 0.
- R2: With no new frame edge and lineEnd low, ramAddr holds its value and shiftEn stays 0 once the current burst has drained.
- R3: Each rising edge of frameAsync gives exactly one loadReq pulse that is one host cycle wide. For this, frameAsync must be held low and high for at least 3 host cycles each.
- R4: A burst advances ramAddr by exactly 1 per step, with steps exactly 2 host cycles apart. A burst has exactly 32 steps, after which ramAddr holds.
- R5: A burst continues from the address where the previous burst stopped. Outside a line-end clear, ramAddr only ever changes to its old value plus 1.
- R6: When lineEnd is high at a clock edge, ramAddr reads 0 after that edge. This is used between bursts.
- R7: The memory contract is that ramData, at each edge, holds the bit stored at the ramAddr value seen at the previous edge. The first address step is seen after edge E, and A is the address before that step. shiftEn is then high for exactly the two host cycles that follow edges E+4 and E+5, and shiftData carries the bit stored at A. At all other times shiftEn is 0.
- R8: Suppose a frame edge arrives while a burst is in progress. It is held, and a fresh 32-step burst starts 4 host cycles after the last step of the running one. Several edges during one burst give only one extra burst.
- R9: From an idle state, the first address step is seen at most 8 host cycles after the frameAsync rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Synchronous active-low reset |
| frameAsync | input | 1 | Frame boundary level from the pixel domain; its rising edge marks a frame |
| lineEnd | input | 1 | Host-domain strobe that clears the read address at the end of a line |
| ramData | input | 1 | Bit returned by the parameter memory |
| ramAddr | output | 14 | Read address into the parameter memory |
| shiftEn | output | 1 | Shift enable to the downstream threshold registers |
| shiftData | output | 1 | Serial parameter bit to the downstream threshold registers |
| loadReq | output | 1 | One-cycle parallel-load request per frame |

## Verification
A monitor samples on the falling clock edge and treats every change of ramAddr as a step. For each step it books an expected shiftEn on the 4th and 5th samples after the step, carrying the bit that the bench's own memory function gives for the old address. Any shiftEn outside those booked slots is flagged. It also checks that step spacing is exactly 2 cycles and that every burst has 32 steps. A line-end strobe is expected to show as address 0 on the first sample after the edge that captures it. The delay from a frame edge to its first step is checked against an 8-cycle bound instead of an exact cycle, because the divided-clock phase may add one cycle. Frame edges that coalesce are checked by the final address after the pipeline has drained.

// File: rtl/frame_param_pkg.sv
package frame_param_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic tick;  // half-rate step slot
    logic adv;   // one parameter bit issued in this slot
  } strobe_t;

endpackage

// File: rtl/fps_control.sv
module fps_control
  import frame_param_pkg::*;
#(
  parameter int BITS_PER_FRAME = 32,
  parameter int SYNC_STAGES    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameAsync,
  output strobe_t strobe,
  output logic    loadReq
);

  localparam int CNT_W = $clog2(BITS_PER_FRAME) + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BITS_PER_FRAME - 1);

  logic [SYNC_STAGES:0] syncQ;
  logic                 frameRise;
  logic                 phase;
  logic                 running;
  logic                 pending;
  logic                 startNow;
  logic                 advNow;
  logic [CNT_W-1:0]     bitCnt;

  // Rising edge after the synchroniser flops
  assign frameRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
  assign startNow  = phase & ~running & pending;
  assign advNow    = phase & running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      phase   <= 1'b0;
      loadReq <= 1'b0;
      pending <= 1'b0;
      running <= 1'b0;
      bitCnt  <= '0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-1:0], frameAsync};
      phase   <= ~phase;
      loadReq <= frameRise;
      pending <= (pending & ~startNow) | frameRise;
      if (startNow) begin
        running <= 1'b1;
      end else if (advNow) begin
        if (bitCnt == LAST_CNT) begin
          running <= 1'b0;
          bitCnt  <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign strobe.tick = phase;
  assign strobe.adv  = advNow;

  // R4
  adv_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    advNow |=> !advNow);

  // R3
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |=> !loadReq);

  // R8
  pending_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !running && phase) |=> running);

endmodule

// File: rtl/fps_datapath.sv
module fps_datapath
  import frame_param_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DELAY_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              lineEnd,
  input  logic              ramData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              shiftEn,
  output logic              shiftData
);

  localparam int LAST_STAGE = DELAY_TICKS;

  logic [ADDR_W-1:0]   addrCnt;
  logic [LAST_STAGE:0] pipeV;
  logic [LAST_STAGE:0] pipeD;

  // Address runs across frames; cleared only by line end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt <= '0;
    end else if (lineEnd) begin
      addrCnt <= '0;
    end else if (strobe.adv) begin
      addrCnt <= addrCnt + 1'b1;
    end
  end

  // Stage 0 captures the read bit; later stages cover memory latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeV <= '0;
      pipeD <= '0;
    end else if (strobe.tick) begin
      pipeV <= {pipeV[LAST_STAGE-1:0], strobe.adv};
      pipeD <= {pipeD[LAST_STAGE-1:0], strobe.adv & ramData};
    end
  end

  assign ramAddr   = addrCnt;
  assign shiftEn   = pipeV[LAST_STAGE];
  assign shiftData = pipeD[LAST_STAGE];

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lineEnd && !strobe.adv) |=> $stable(addrCnt));

  // R6
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> (addrCnt == '0));

  // R7
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftEn) |=> shiftEn);

endmodule

// File: rtl/frame_param_streamer.sv
module frame_param_streamer
  import frame_param_pkg::*;
#(
  parameter int ADDR_W         = 14,
  parameter int BITS_PER_FRAME = 32,
  parameter int DELAY_TICKS    = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameAsync,
  input  logic              lineEnd,
  input  logic              ramData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              shiftEn,
  output logic              shiftData,
  output logic              loadReq
);

  strobe_t strobe;

  fps_control #(
    .BITS_PER_FRAME(BITS_PER_FRAME),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .frameAsync(frameAsync),
    .strobe    (strobe),
    .loadReq   (loadReq)
  );

  fps_datapath #(
    .ADDR_W     (ADDR_W),
    .DELAY_TICKS(DELAY_TICKS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lineEnd  (lineEnd),
    .ramData  (ramData),
    .ramAddr  (ramAddr),
    .shiftEn  (shiftEn),
    .shiftData(shiftData)
  );

endmodule

// File: tb/frame_param_streamer_tb.sv
module frame_param_streamer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameAsync = 1'b0;
  logic        lineEnd = 1'b0;
  logic        ramData = 1'b0;
  logic [13:0] ramAddr;
  logic        shiftEn;
  logic        shiftData;
  logic        loadReq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit monOn = 1'b0;
  bit [7:0] expEn = '0;
  bit [7:0] expD = '0;
  logic [13:0] prevAddr = '0;
  bit lePend = 1'b0;
  int lastStep = -100;
  int runLen = 0;
  int loadCnt = 0;
  bit prevLoad = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  frame_param_streamer u_dut (
    .clk(clk), .rstN(rstN), .frameAsync(frameAsync), .lineEnd(lineEnd),
    .ramData(ramData), .ramAddr(ramAddr), .shiftEn(shiftEn),
    .shiftData(shiftData), .loadReq(loadReq)
  );

  function automatic logic ramBit(input logic [13:0] a);
    logic [31:0] h;
    h = {18'd0, a} * 32'h9E3779B1;
    return h[19] ^ h[11] ^ a[0];
  endfunction

  // Memory model: one-cycle registered read
  always @(posedge clk) ramData <= ramBit(ramAddr);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #5;
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (monOn) begin
      int slot;
      cyc++;
      slot = cyc % 8;
      if (expEn[slot]) begin
        chk(shiftEn == 1'b1, "R7", "shiftEn due", int'(shiftEn), 1);
        chk(shiftData == expD[slot], "R7", "shiftData", int'(shiftData), int'(expD[slot]));
      end else if (shiftEn) begin
        chk(1'b0, "R7", "unexpected shiftEn", 1, 0);
      end
      expEn[slot] = 1'b0;
      if (lePend) begin
        chk(ramAddr == 14'd0, "R6", "address after lineEnd", int'(ramAddr), 0);
      end else if (ramAddr != prevAddr) begin
        chk(ramAddr == prevAddr + 14'd1, "R5", "address step", int'(ramAddr), int'(prevAddr) + 1);
        expEn[(cyc + 4) % 8] = 1'b1;
        expD[(cyc + 4) % 8]  = ramBit(prevAddr);
        expEn[(cyc + 5) % 8] = 1'b1;
        expD[(cyc + 5) % 8]  = ramBit(prevAddr);
        if (cyc - lastStep == 2) begin
          runLen++;
        end else begin
          if (runLen != 0) chk(runLen == 32, "R4", "burst length", runLen, 32);
          runLen = 1;
        end
        lastStep = cyc;
      end
      lePend = lineEnd;
      if (loadReq) begin
        loadCnt++;
        chk(!prevLoad, "R3", "loadReq width", 2, 1);
      end
      prevLoad = loadReq;
      prevAddr = ramAddr;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int k;
    int expAddr;
    int edges;
    logic [13:0] a0;
    void'($urandom(32'd9127));

    // R1: reset values
    step(3);
    chk(ramAddr == 14'd0, "R1", "ramAddr in reset", int'(ramAddr), 0);
    chk(shiftEn == 1'b0, "R1", "shiftEn in reset", int'(shiftEn), 0);
    chk(shiftData == 1'b0, "R1", "shiftData in reset", int'(shiftData), 0);
    chk(loadReq == 1'b0, "R1", "loadReq in reset", int'(loadReq), 0);
    rstN = 1'b1;
    monOn = 1'b1;

    // R2: idle without a frame edge
    step(30);
    chk(ramAddr == 14'd0, "R2", "idle address", int'(ramAddr), 0);
    chk(shiftEn == 1'b0, "R2", "idle shiftEn", int'(shiftEn), 0);

    // R9: latency of first step from idle
    a0 = ramAddr;
    frameAsync = 1'b1;
    k = 0;
    for (int i = 1; i <= 12; i++) begin
      step(1);
      if (ramAddr != a0 && k == 0) k = i;
    end
    chk(k >= 1 && k <= 8, "R9", "first step latency", k, 8);
    step(100);
    chk(ramAddr == 14'd32, "R4", "address after one burst", int'(ramAddr), 32);
    chk(loadCnt == 1, "R3", "loadReq count", loadCnt, 1);

    // R8: edges during a running burst coalesce into one extra burst
    frameAsync = 1'b0; step(40);
    frameAsync = 1'b1; step(20);
    frameAsync = 1'b0; step(4);
    frameAsync = 1'b1; step(4);
    frameAsync = 1'b0; step(4);
    frameAsync = 1'b1; step(200);
    chk(ramAddr == 14'd96, "R8", "address after held edges", int'(ramAddr), 96);
    chk(loadCnt == 4, "R3", "loadReq count", loadCnt, 4);

    // R2: holds while idle
    step(30);
    chk(ramAddr == 14'd96, "R2", "idle hold", int'(ramAddr), 96);

    // R6: line end clears
    lineEnd = 1'b1; step(1); lineEnd = 1'b0;
    chk(ramAddr == 14'd0, "R6", "cleared address", int'(ramAddr), 0);
    step(2);

    // Random frames with occasional line ends
    expAddr = 0;
    edges = 0;
    for (int i = 0; i < 25; i++) begin
      int lo;
      int hi;
      lo = 40 + int'($urandom % 41);
      hi = 40 + int'($urandom % 41);
      frameAsync = 1'b0;
      step(lo - 2);
      if ($urandom % 3 == 0) begin
        lineEnd = 1'b1; step(1); lineEnd = 1'b0;
        expAddr = 0;
        step(1);
      end else begin
        step(2);
      end
      frameAsync = 1'b1;
      expAddr += 32;
      edges++;
      step(hi);
    end
    step(150);
    chk(int'(ramAddr) == expAddr, "R5", "address continuity", int'(ramAddr), expAddr);
    chk(loadCnt == 4 + edges, "R3", "loadReq count", loadCnt, 4 + edges);
    chk(runLen == 32, "R4", "last burst length", runLen, 32);
    chk(shiftEn == 1'b0, "R2", "drained shiftEn", int'(shiftEn), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule